// File: doc/BRIEF.md
# Event Status Register with Enable Mask

This block collects instrument event pulses into a sticky 16-bit event status register. It applies a software-written 8-bit enable mask to that register and produces one event summary bit, which feeds the instrument's status byte. A host reads the event register through a read strobe. The read returns the current contents and empties the register. A separate clear-status strobe also empties the register but leaves the mask unchanged.

Only the low byte carries conditions. The upper byte is always zero, and bit positions 6 and 1 are reserved: they never latch an event and never hold a mask bit. After power-on reset, the register holds 0x0080 (only bit 7 set), the mask is zero and the summary is low. Once the summary goes high, it stays high until a read or a clear-status, even if the enabling mask bit is removed in the meantime.

Top module: `evt_status_unit`

## Requirements
- R1: On synchronous active-low reset, `evt_rdata` reads 0x0080, `mask_rdata` reads 0x00 and `summary` is 0.
- R2: Bits 15..8 of `evt_rdata` always read as 0.
- R3: Pulses on `evt_pulse[6]` and `evt_pulse[1]` are ignored. Event bits 6 and 1 always read as 0.
- R4: A one-cycle pulse on `evt_pulse[i]` (any non-reserved i) sets event bit i at the next clock edge. The bit stays set after the pulse ends, until a read or a clear-status.
- R5: While `evt_rd` is high, `evt_rdata` shows the register contents. After that clock edge the register is 0, apart from R6.
- R6: An event pulse in the same cycle as a read or clear-status is kept. The read returns the old value, and the new bit is set afterwards.
- R7: `clr_stat` clears the event register at the next edge and leaves the enable mask unchanged.
- R8: `mask_wr` loads `mask_wdata` into the mask at the next edge. Writes to mask bits 6 and 1 are ignored, and those bits read back as 0 on `mask_rdata`.
- R9: `summary` is 1 in every cycle where any event bit and its mask bit are both 1. It rises at the same edge that sets the event bit or the mask bit.
- R10: Once set, `summary` stays 1 until a read or a clear-status, even if the mask bit is later cleared. After a read or clear-status, it equals the OR of the enabled events that arrived in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| evt_pulse | input | 8 | One-cycle event pulses, one per low register bit |
| evt_rd | input | 1 | Read strobe: the register empties at this edge |
| evt_rdata | output | 16 | Current event register contents |
| mask_wr | input | 1 | Enable mask write strobe |
| mask_wdata | input | 8 | Enable mask write data |
| mask_rdata | output | 8 | Current enable mask |
| clr_stat | input | 1 | Clear-status command strobe |
| summary | output | 1 | Enabled-event summary bit |

## Verification
Every state change (event capture, clear on read or clear-status, mask load, summary set or release) is due exactly one clock edge after the stimulus cycle. The bench drives each stimulus at a falling edge and compares all three outputs at the following falling edge, after exactly one rising edge. The read data itself is combinational from the register, so the read-return check samples `evt_rdata` inside the strobe cycle, before the edge that empties it.

// File: rtl/evt_stat_pkg.sv
// Package: shared widths and constants for the event status unit.
// Assumes: only the low byte of the register carries conditions.
package evt_stat_pkg;
    localparam int          EVT_REG_W  = 16;
    localparam int          EVT_LOW_W  = 8;
    localparam logic [7:0]  EVT_RSVD   = 8'h42;   // bit positions 6 and 1
    localparam logic [7:0]  EVT_PWR_ON = 8'h80;   // bit 7 set at power-on
endpackage

// File: rtl/evt_capture.sv
// Module: evt_capture
// Latches event pulses into sticky bits. A read or clear-status empties the
// bits; a pulse arriving in that same cycle survives. Reserved positions are
// tied to zero. Assumes a synchronous active-low reset.
module evt_capture #(
    parameter int              LOW_W  = evt_stat_pkg::EVT_LOW_W,
    parameter logic [LOW_W-1:0] RSVD  = evt_stat_pkg::EVT_RSVD,
    parameter logic [LOW_W-1:0] PWRON = evt_stat_pkg::EVT_PWR_ON
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOW_W-1:0] pulse,
    input  logic             wipe,
    output logic [LOW_W-1:0] evt_q,
    output logic [LOW_W-1:0] evt_next
);
    localparam logic [LOW_W-1:0] LIVE = ~RSVD;

    for (genvar i = 0; i < LOW_W; i++) begin : g_bit
        if (RSVD[i]) begin : g_rsvd
            assign evt_q[i]    = 1'b0;
            assign evt_next[i] = 1'b0;
        end else begin : g_live
            logic bit_q;
            // Next value: keep the bit unless wiped; a new pulse always sets it.
            assign evt_next[i] = (bit_q & ~wipe) | pulse[i];
            // Sticky event flop with power-on value.
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= PWRON[i];
                else        bit_q <= evt_next[i];
            end
            assign evt_q[i] = bit_q;
        end
    end

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe |=> ((evt_q & $past(evt_q)) == $past(evt_q)));            // R4
    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pulse) & LIVE) & ~evt_q) == '0));              // R4
    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> ((evt_q & ~$past(pulse)) == '0));                       // R5
endmodule

// File: rtl/evt_mask_reg.sv
// Module: evt_mask_reg
// Holds the enable mask. Writes land at the next edge; reserved positions
// ignore writes and read as zero. Assumes a synchronous active-low reset.
module evt_mask_reg #(
    parameter int               LOW_W = evt_stat_pkg::EVT_LOW_W,
    parameter logic [LOW_W-1:0] RSVD  = evt_stat_pkg::EVT_RSVD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [LOW_W-1:0] wdata,
    output logic [LOW_W-1:0] mask_q,
    output logic [LOW_W-1:0] mask_next
);
    // Next mask: load filtered write data, otherwise hold.
    always_comb begin
        mask_next = wr ? (wdata & ~RSVD) : mask_q;
    end

    // Mask flop, cleared at power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_next;
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_q));                                        // R8
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mask_q == ($past(wdata) & ~RSVD)));                      // R8
    AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((mask_q & RSVD) == '0));                                 // R8
endmodule

// File: rtl/evt_summary.sv
// Module: evt_summary
// Sticky summary flag. It sets as soon as an enabled event is present and
// releases only on read or clear-status, when it is reloaded from the enabled
// events that arrive in that same cycle. Assumes next-state inputs from the
// register and mask blocks.
module evt_summary #(
    parameter int LOW_W = evt_stat_pkg::EVT_LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic [LOW_W-1:0] evt_next,
    input  logic [LOW_W-1:0] mask_next,
    output logic             sum_q
);
    logic hit_next;

    // Any enabled event after this edge.
    always_comb begin
        hit_next = |(evt_next & mask_next);
    end

    // Summary flop: reload on wipe, otherwise accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)    sum_q <= 1'b0;
        else if (wipe) sum_q <= hit_next;
        else           sum_q <= sum_q | hit_next;
    end

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q && !wipe) |=> sum_q);                                     // R10
endmodule

// File: rtl/evt_status_unit.sv
// Module: evt_status_unit (top)
// Event status register with enable mask and summary output. The register
// is zero-extended to the full width. Assumes one-cycle strobes and a
// synchronous active-low power-on reset.
module evt_status_unit #(
    parameter int               REG_W = evt_stat_pkg::EVT_REG_W,
    parameter int               LOW_W = evt_stat_pkg::EVT_LOW_W,
    parameter logic [LOW_W-1:0] RSVD  = evt_stat_pkg::EVT_RSVD,
    parameter logic [LOW_W-1:0] PWRON = evt_stat_pkg::EVT_PWR_ON
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOW_W-1:0] evt_pulse,
    input  logic             evt_rd,
    output logic [REG_W-1:0] evt_rdata,
    input  logic             mask_wr,
    input  logic [LOW_W-1:0] mask_wdata,
    output logic [LOW_W-1:0] mask_rdata,
    input  logic             clr_stat,
    output logic             summary
);
    localparam int PAD_W = REG_W - LOW_W;

    logic             wipe;
    logic [LOW_W-1:0] evt_q, evt_next, mask_q, mask_next;

    // A read and a clear-status empty the register the same way.
    assign wipe = evt_rd | clr_stat;

    evt_capture #(.LOW_W(LOW_W), .RSVD(RSVD), .PWRON(PWRON)) u_cap (
        .clk(clk), .rst_n(rst_n), .pulse(evt_pulse), .wipe(wipe),
        .evt_q(evt_q), .evt_next(evt_next));

    evt_mask_reg #(.LOW_W(LOW_W), .RSVD(RSVD)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(mask_wdata),
        .mask_q(mask_q), .mask_next(mask_next));

    evt_summary #(.LOW_W(LOW_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .evt_next(evt_next),
        .mask_next(mask_next), .sum_q(summary));

    // Zero-extend the register to the full read width.
    assign evt_rdata  = {{PAD_W{1'b0}}, evt_q};
    assign mask_rdata = mask_q;

    AST_SUM_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_q & mask_q)) |-> summary);                                // R9
    AST_CLR_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat && !mask_wr) |=> $stable(mask_rdata));                 // R7
endmodule

// File: tb/evt_status_unit_test.sv
module evt_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_pulse = '0;
    logic        evt_rd = 1'b0;
    logic [15:0] evt_rdata;
    logic        mask_wr = 1'b0;
    logic [7:0]  mask_wdata = '0;
    logic [7:0]  mask_rdata;
    logic        clr_stat = 1'b0;
    logic        summary;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    evt_status_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_rd(evt_rd),
        .evt_rdata(evt_rdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .mask_rdata(mask_rdata), .clr_stat(clr_stat), .summary(summary));

    // Vector: req[47:44] pulse[43:36] rd[35] clr[34] wr[33] wdata[32:25]
    //         exp_evt[24:9] exp_mask[8:1] exp_sum[0]; expected after one edge.
    localparam int NV = 15;
    localparam logic [47:0] VEC [NV] = '{
        {4'd1, 8'h00, 1'b0,1'b0,1'b0, 8'h00, 16'h0080, 8'h00, 1'b0}, // R1 idle
        {4'd8, 8'h00, 1'b0,1'b0,1'b1, 8'hFF, 16'h0080, 8'hBD, 1'b1}, // R8 R9
        {4'd5, 8'h00, 1'b1,1'b0,1'b0, 8'h00, 16'h0000, 8'hBD, 1'b0}, // R5
        {4'd3, 8'h42, 1'b0,1'b0,1'b0, 8'h00, 16'h0000, 8'hBD, 1'b0}, // R3
        {4'd4, 8'h01, 1'b0,1'b0,1'b0, 8'h00, 16'h0001, 8'hBD, 1'b1}, // R4
        {4'd4, 8'h00, 1'b0,1'b0,1'b0, 8'h00, 16'h0001, 8'hBD, 1'b1}, // R4 sticky
        {4'd10,8'h00, 1'b0,1'b0,1'b1, 8'h00, 16'h0001, 8'h00, 1'b1}, // R10
        {4'd2, 8'hA0, 1'b0,1'b0,1'b0, 8'h00, 16'h00A1, 8'h00, 1'b1}, // R2
        {4'd7, 8'h00, 1'b0,1'b1,1'b0, 8'h00, 16'h0000, 8'h00, 1'b0}, // R7
        {4'd9, 8'h04, 1'b0,1'b0,1'b0, 8'h00, 16'h0004, 8'h00, 1'b0}, // R9 masked
        {4'd9, 8'h00, 1'b0,1'b0,1'b1, 8'h04, 16'h0004, 8'h04, 1'b1}, // R9 enable
        {4'd6, 8'h08, 1'b1,1'b0,1'b0, 8'h00, 16'h0008, 8'h04, 1'b0}, // R6 read
        {4'd6, 8'h04, 1'b0,1'b1,1'b0, 8'h00, 16'h0004, 8'h04, 1'b1}, // R6 clear
        {4'd8, 8'h00, 1'b0,1'b0,1'b1, 8'h42, 16'h0004, 8'h00, 1'b1}, // R8 rsvd
        {4'd10,8'h80, 1'b1,1'b0,1'b0, 8'h00, 16'h0080, 8'h00, 1'b0}  // R10 release
    };

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic idle_inputs;
        evt_pulse = '0; evt_rd = 1'b0; clr_stat = 1'b0;
        mask_wr = 1'b0; mask_wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, "evt after reset", evt_rdata, 16'h0080);
        check(1, "mask after reset", {8'h00, mask_rdata}, 16'h0000);
        check(1, "summary after reset", {15'd0, summary}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            evt_pulse = v[43:36]; evt_rd = v[35]; clr_stat = v[34];
            mask_wr = v[33]; mask_wdata = v[32:25];
            @(negedge clk);
            check(int'(v[47:44]), "vector evt", evt_rdata, v[24:9]);
            check(int'(v[47:44]), "vector mask", {8'h00, mask_rdata}, {8'h00, v[8:1]});
            check(int'(v[47:44]), "vector summary", {15'd0, summary}, {15'd0, v[0]});
        end
        idle_inputs();

        // R5 / R6 read returns old value within the strobe cycle
        evt_pulse = 8'h10; @(negedge clk); evt_pulse = '0;   // reg = 0x0090
        evt_rd = 1'b1; evt_pulse = 8'h20;
        #1 check(5, "read data during strobe", evt_rdata, 16'h0090);
        @(negedge clk); idle_inputs();
        check(6, "event kept after read", evt_rdata, 16'h0020);
        @(negedge clk);
        check(4, "kept event sticky", evt_rdata, 16'h0020);

        // R1 reset in mid-run restores power-on values
        mask_wr = 1'b1; mask_wdata = 8'hFF; @(negedge clk); idle_inputs();
        rst_n = 1'b0; @(negedge clk);
        check(1, "evt after re-reset", evt_rdata, 16'h0080);
        check(1, "mask after re-reset", {8'h00, mask_rdata}, 16'h0000);
        check(1, "summary after re-reset", {15'd0, summary}, 16'h0000);
        rst_n = 1'b1;

        // R3 reserved pulses with full mask leave summary low
        mask_wr = 1'b1; mask_wdata = 8'hFF; evt_rd = 1'b1; @(negedge clk);
        idle_inputs(); evt_pulse = 8'h42; @(negedge clk); idle_inputs();
        check(3, "reserved bits stay zero", evt_rdata, 16'h0000);
        check(3, "reserved pulse no summary", {15'd0, summary}, 16'h0000);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule